// File: doc/BRIEF.md
# Alarm Flag and Interrupt Controller

This block keeps a small status register with two sticky flags and drives an active-low interrupt line from them. One flag records that the oscillator has stopped at some point. The other records that an external down-counter has reached zero. Software reads both flags through a simple register port and clears them by writing 0 to their bit. Writing 1 to a bit has no effect.

Three control inputs choose how the interrupt line behaves. In level mode the line stays low for as long as the alarm flag is set. In pulse mode a counter-zero event drives the line low for a fixed number of slow timebase ticks, and the flag clears itself when that window ends. A software clear cannot cut that window short. In every other setting the line stays high. The counter, the serial bus slave, the oscillator and the open-drain pad sit outside this block.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The status register is decoded at address 0x08. Bit 7 is the oscillator-stop flag, bit 0 is the alarm flag, and bits 6 to 1 read 0. A read of any other address returns 0, and a write to any other address changes neither flag.
- R2: After reset the oscillator-stop flag is 1, the alarm flag is 0 and `irq_n` is high.
- R3: A cycle with `osc_stop` high sets the oscillator-stop flag. A status write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it as it was. When a set and a clear fall in the same cycle, the set wins.
- R4: A cycle with `cnt_zero` high sets the alarm flag. A status write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it as it was. When a set and a clear fall in the same cycle, the set wins.
- R5: Level mode is `irq_ctl`=1, `wd_mode`=0, `alm_ie`=1. In level mode `irq_n` is low exactly while the alarm flag is 1.
- R6: Pulse mode is `irq_ctl`=1, `wd_mode`=1, `alm_ie`=1. In pulse mode a counter-zero event drives `irq_n` low from the next clock edge. `irq_n` returns high, and the alarm flag clears, on the edge that takes the PULSE_TICKS-th `tick` after the event.
- R7: During an active pulse, a status write with bit 0 = 0 clears the alarm flag but leaves `irq_n` low for the full window.
- R8: A counter-zero event during an active pulse restarts the window at PULSE_TICKS ticks and keeps the alarm flag set. This also holds when the event falls on the edge of the final tick.
- R9: When `irq_ctl`=0 or `alm_ie`=0, `irq_n` is high. Leaving pulse mode drops any active pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| osc_stop | input | 1 | Oscillator-stopped indication |
| cnt_zero | input | 1 | One-cycle strobe when the down-counter reaches zero |
| irq_ctl | input | 1 | Interrupt-control bit; 1 routes the alarm to `irq_n` |
| wd_mode | input | 1 | 1 selects pulse mode, 0 selects level mode |
| alm_ie | input | 1 | Alarm interrupt enable |
| tick | input | 1 | Slow timebase enable that counts the pulse width |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The hard collisions are a hardware set of a flag against a software clear of that flag, and the final tick of a pulse against a new counter-zero event. Directed steps raise `cnt_zero` or `osc_stop` in the same cycle as a clearing write, and raise `cnt_zero` on the edge that carries the last tick of a window. A long random run, with dense strobes and status writes, produces many more of these overlaps. After every edge, the bench compares the read-back flags and `irq_n` with a model built from the priority rules: a set beats a clear, and a restart beats the end of a window.

// File: rtl/alm_pkg.sv
package alm_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned OSF_POS   = 7;
  localparam int unsigned AF_POS    = 0;
  localparam logic [7:0]  STAT_ADDR = 8'h08;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'd0,
    IRQ_LEVEL = 2'd1,
    IRQ_PULSE = 2'd2
  } irq_mode_e;

  function automatic irq_mode_e irq_mode_decode(input logic ctl,
                                                input logic wd,
                                                input logic ie);
    irq_mode_e m;
    if (!(ctl && ie)) m = IRQ_OFF;
    else if (wd)      m = IRQ_PULSE;
    else              m = IRQ_LEVEL;
    return m;
  endfunction

endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alm_osf_flag.sv
module alm_osf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Hardware set has priority over a software clear in the same cycle.
  always_comb begin
    flag_en = set_i || (wr_i && !wbit_i);
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/alm_alarm_unit.sv
module alm_alarm_unit #(
  parameter int unsigned PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic pulse_mode_i,
  input  logic tick_i,
  output logic af_o,
  output logic pulse_o
);

  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] LAST_VAL = CW'(1);

  logic          af_q, af_d, af_en;
  logic          act_q, act_d, act_en;
  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en;
  logic          win_end;

  // Pulse window timer
  always_comb begin
    win_end = 1'b0;
    act_d   = act_q;
    act_en  = 1'b0;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    if (!pulse_mode_i) begin
      act_d  = 1'b0;
      act_en = act_q;
    end else if (zero_i) begin
      act_d  = 1'b1;
      act_en = 1'b1;
      rem_d  = LOAD_VAL;
      rem_en = 1'b1;
    end else if (act_q && tick_i) begin
      if (rem_q == LAST_VAL) begin
        act_d   = 1'b0;
        act_en  = 1'b1;
        win_end = 1'b1;
      end else begin
        rem_d  = rem_q - LAST_VAL;
        rem_en = 1'b1;
      end
    end
  end

  // Alarm flag: set > end-of-window clear > software clear
  always_comb begin
    af_d  = af_q;
    af_en = 1'b0;
    if (zero_i) begin
      af_d  = 1'b1;
      af_en = 1'b1;
    end else if (win_end || (wr_i && !wbit_i)) begin
      af_d  = 1'b0;
      af_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     af_q <= 1'b0;
    else if (af_en) af_q <= af_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign af_o    = af_q;
  assign pulse_o = act_q;

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alm_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  input  logic       osc_stop,
  input  logic       cnt_zero,
  input  logic       irq_ctl,
  input  logic       wd_mode,
  input  logic       alm_ie,
  input  logic       tick,
  output logic       irq_n
);

  logic      rst_sync_n;
  logic      stat_wr;
  logic      osf_q;
  logic      af_q;
  logic      pulse_act;
  irq_mode_e mode;

  alm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    stat_wr = reg_we && (reg_addr == STAT_ADDR);
    mode    = irq_mode_decode(irq_ctl, wd_mode, alm_ie);
  end

  alm_osf_flag u_osf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (osc_stop),
    .wr_i   (stat_wr),
    .wbit_i (reg_wdata[OSF_POS]),
    .flag_o (osf_q)
  );

  alm_alarm_unit #(.PULSE_TICKS(PULSE_TICKS)) u_alarm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .zero_i       (cnt_zero),
    .wr_i         (stat_wr),
    .wbit_i       (reg_wdata[AF_POS]),
    .pulse_mode_i (mode == IRQ_PULSE),
    .tick_i       (tick),
    .af_o         (af_q),
    .pulse_o      (pulse_act)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR) begin
      reg_rdata[OSF_POS] = osf_q;
      reg_rdata[AF_POS]  = af_q;
    end
  end

  always_comb begin
    case (mode)
      IRQ_LEVEL: irq_n = !af_q;
      IRQ_PULSE: irq_n = !pulse_act;
      default:   irq_n = 1'b1;
    endcase
  end

endmodule

// File: rtl/alm_irq_checker.sv
module alm_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       osc_stop,
  input logic       cnt_zero,
  input logic       irq_ctl,
  input logic       wd_mode,
  input logic       alm_ie,
  input logic       tick,
  input logic       irq_n,
  input logic       osf,
  input logic       af,
  input logic       act
);

  // R1: unused status bits read as zero
  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h08) |-> (reg_rdata[6:1] == 6'd0));

  // R3: oscillator-stop indication sets the flag
  assert_osf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> osf);

  // R4: counter-zero strobe sets the alarm flag
  assert_af_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |=> af);

  // R9: interrupt stays high when not routed or not enabled
  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ctl && alm_ie) |-> irq_n);

  // R5: level mode follows the alarm flag
  assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ctl && !wd_mode && alm_ie) |-> (irq_n == !af));

  // R7: without a tick the pulse window cannot end
  assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick && irq_ctl && wd_mode && alm_ie) |=> act);

endmodule

bind alarm_irq_ctrl alm_irq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .osc_stop  (osc_stop),
  .cnt_zero  (cnt_zero),
  .irq_ctl   (irq_ctl),
  .wd_mode   (wd_mode),
  .alm_ie    (alm_ie),
  .tick      (tick),
  .irq_n     (irq_n),
  .osf       (osf_q),
  .af        (af_q),
  .act       (pulse_act)
);

// File: tb/alarm_irq_ctrl_bench.sv
`timescale 1ns/100ps
module alarm_irq_ctrl_bench;

  localparam int unsigned P = 8;

  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       osc_stop;
  logic       cnt_zero;
  logic       irq_ctl;
  logic       wd_mode;
  logic       alm_ie;
  logic       tick;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic m_osf, m_af, m_act;
  int   m_rem;

  alarm_irq_ctrl #(.PULSE_TICKS(P)) u_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .osc_stop(osc_stop),
    .cnt_zero(cnt_zero), .irq_ctl(irq_ctl), .wd_mode(wd_mode),
    .alm_ie(alm_ie), .tick(tick), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_rdata(input logic [7:0] a, input logic o, input logic f);
    return (a == 8'h08) ? {o, 6'd0, f} : 8'h00;
  endfunction

  function automatic logic exp_irq_n(input logic c, input logic w, input logic e,
                                     input logic f, input logic a);
    if (!(c && e)) return 1'b1;
    if (w)         return !a;
    return !f;
  endfunction

  task automatic model_edge();
    logic pm, wr, wend;
    pm   = irq_ctl && wd_mode && alm_ie;
    wr   = reg_we && (reg_addr == 8'h08);
    wend = 1'b0;
    if (osc_stop)               m_osf = 1'b1;
    else if (wr && !reg_wdata[7]) m_osf = 1'b0;
    if (!pm) m_act = 1'b0;
    else if (cnt_zero) begin m_act = 1'b1; m_rem = P; end
    else if (m_act && tick) begin
      if (m_rem == 1) begin m_act = 1'b0; wend = 1'b1; end
      else m_rem = m_rem - 1;
    end
    if (cnt_zero)                          m_af = 1'b1;
    else if (wend || (wr && !reg_wdata[0])) m_af = 1'b0;
  endtask

  task automatic compare(input string tag);
    logic [7:0] er;
    logic       ei;
    er = exp_rdata(reg_addr, m_osf, m_af);
    ei = exp_irq_n(irq_ctl, wd_mode, alm_ie, m_af, m_act);
    checks++;
    if (reg_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata actual=%02h expected=%02h", tag, reg_rdata, er);
    end
    checks++;
    if (irq_n !== ei) begin
      errors++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", tag, irq_n, ei);
    end
  endtask

  // inputs set at a falling edge; then one clock, then compare
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    reg_we = 1'b0; osc_stop = 1'b0; cnt_zero = 1'b0; tick = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    reg_addr = 8'h08; reg_wdata = d; reg_we = 1'b1;
  endtask

  task automatic set_mode(input logic c, input logic w, input logic e);
    irq_ctl = c; wd_mode = w; alm_ie = e;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog cycles actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_addr = 8'h08; reg_wdata = 8'h00; reg_we = 1'b0;
    osc_stop = 1'b0; cnt_zero = 1'b0; tick = 1'b0;
    set_mode(1'b0, 1'b0, 1'b0);
    m_osf = 1'b1; m_af = 1'b0; m_act = 1'b0; m_rem = 0;
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1'b1;
    repeat (3) step("R2 release");

    // R1: other address reads zero, write there has no effect
    reg_addr = 8'h09; step("R1 other addr read");
    reg_addr = 8'h07; reg_wdata = 8'h00; reg_we = 1'b1; step("R1 foreign write");
    reg_addr = 8'h08; step("R1 status layout");

    // R3: write 1 keeps, write 0 clears, set beats clear
    wr_stat(8'hFF); step("R3 write one keeps");
    wr_stat(8'h7F); step("R3 write zero clears");
    osc_stop = 1'b1; step("R3 set");
    wr_stat(8'h00); osc_stop = 1'b1; step("R3 set wins");

    // R4
    cnt_zero = 1'b1; step("R4 set");
    wr_stat(8'h81); step("R4 write one keeps");
    wr_stat(8'h00); cnt_zero = 1'b1; step("R4 set wins");
    wr_stat(8'h00); step("R4 clear");

    // R9 / R5
    set_mode(1'b0, 1'b0, 1'b1); cnt_zero = 1'b1; step("R9 ctl off");
    set_mode(1'b1, 1'b0, 1'b0); step("R9 ie off");
    set_mode(1'b1, 1'b0, 1'b1); step("R5 level low");
    repeat (3) step("R5 level hold");
    wr_stat(8'h00); step("R5 level release");

    // R6: full pulse window with ticks on every cycle
    set_mode(1'b1, 1'b1, 1'b1); cnt_zero = 1'b1; step("R6 start");
    for (int i = 0; i < P + 2; i++) begin tick = 1'b1; step("R6 window"); end

    // R7: software clear mid-pulse does not shorten
    cnt_zero = 1'b1; step("R7 start");
    tick = 1'b1; step("R7 tick");
    wr_stat(8'h00); step("R7 clear mid-pulse");
    for (int i = 0; i < P; i++) begin tick = (i % 2 == 0); step("R7 window"); end

    // R8: retrigger, including on the final tick
    cnt_zero = 1'b1; step("R8 start");
    for (int i = 0; i < P - 1; i++) begin tick = 1'b1; step("R8 run"); end
    tick = 1'b1; cnt_zero = 1'b1; step("R8 restart on last tick");
    for (int i = 0; i < 3; i++) begin tick = 1'b1; step("R8 after restart"); end
    cnt_zero = 1'b1; step("R8 mid restart");
    for (int i = 0; i < P + 1; i++) begin tick = 1'b1; step("R8 tail"); end

    // R9: leaving pulse mode drops the pulse
    cnt_zero = 1'b1; step("R9 pulse start");
    set_mode(1'b1, 1'b0, 1'b1); step("R9 leave pulse");
    set_mode(1'b1, 1'b1, 1'b1); step("R9 back to pulse");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 31) == 0)
        set_mode(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom_range(0, 3) != 0));
      reg_addr  = ($urandom_range(0, 3) != 0) ? 8'h08 : 8'($urandom);
      reg_wdata = 8'($urandom);
      reg_we    = ($urandom_range(0, 7) == 0);
      osc_stop  = ($urandom_range(0, 15) == 0);
      cnt_zero  = ($urandom_range(0, 23) == 0);
      tick      = ($urandom_range(0, 1) == 0);
      step("R3/R4/R5/R6/R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule